// File: doc/BRIEF.md
# Serial flash quad-enable sequencer

This block turns on the quad-I/O enable flag of a serial NOR flash before any quad-I/O fast read is let through to the device. A 3-bit procedure code selects how the flag is written. The code comes from the flash's discoverable parameter table and is parsed elsewhere. With code 100b the block writes both status bytes without ever reading the second status register. With code 101b it reads the second status register first, and it leaves the device untouched when the quad bit is already set.

The block talks to a byte-level single-lane SPI serializer. It holds an active-low select line around each command, presents one byte at a time with a request, and takes the exchanged byte back with an acknowledge. After the status write it polls the write-in-progress flag until the slow non-volatile write is finished. Only then does it raise a ready flag, and that flag gates the grant for the quad read path. A poll limit ends a device that never finishes in an error, and an unknown procedure code is rejected at once.

Top module: `qe_seq`

## Requirements
- R1: While reset is low and after it is released, `spi_cs_n` is 1, `byte_req` is 0, `quad_ready` is 0, `err` is 0 and `qread_grant` is 0.
- R2: A `start` with a `mode` other than 100b or 101b raises `err` on the next clock. The SPI side stays silent: `spi_cs_n` stays 1 and `byte_req` stays 0.
- R3: Mode 100b sends, each in its own select frame, the bytes [05h,00h], then [06h], then [01h, SR1, 02h], then polls. SR1 is the byte returned in the first frame. The byte 35h is never sent.
- R4: Mode 101b starts with [05h,00h] then [35h,00h]. If bit 1 of the second returned byte is 1, `quad_ready` rises and no further byte is sent.
- R5: Mode 101b with bit 1 of that byte clear continues with [06h] and [01h, SR1, SR2 | 02h], where SR1 and SR2 are the bytes read back earlier, and then polls.
- R6: After the status write the block repeats [05h,00h] frames while bit 0 of the returned byte is 1. The first frame that returns bit 0 = 0 raises `quad_ready` on the clock that takes that byte, and no byte follows.
- R7: `byte_req` is high only while `spi_cs_n` is 0. `byte_out` is held until `byte_ack`. Between two frames of a run, `spi_cs_n` stays 1 for at least `GAP` clock cycles.
- R8: If `MAX_POLLS` polls in a row all return bit 0 = 1, `err` rises when the last of them is acknowledged, and nothing more is sent. If poll number `MAX_POLLS` returns bit 0 = 0, the result is `quad_ready`, not `err`.
- R9: `qread_grant` is 1 exactly when `qread_req` is 1 and `quad_ready` is 1.
- R10: A `start` while finished (ready or error) clears both flags on the next clock and runs the selected procedure again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the procedure (taken when idle or finished) |
| mode | input | 3 | Procedure code from the parameter table |
| spi_cs_n | output | 1 | Flash select, active low |
| byte_req | output | 1 | Byte exchange request to the serializer |
| byte_out | output | 8 | Byte to shift out |
| byte_ack | input | 1 | One-cycle pulse: byte exchanged |
| byte_in | input | 8 | Byte shifted in, valid with `byte_ack` |
| quad_ready | output | 1 | Quad enable confirmed and device idle |
| err | output | 1 | Bad procedure code or poll limit reached |
| qread_req | input | 1 | Request from the quad fast-read path |
| qread_grant | output | 1 | Quad fast read permitted |

## Verification
Two things can land on the same clock. One is the poll that finally reports the device idle. The other is the poll counter reaching its limit. The bench drives both sides of that boundary: the simulated flash stays busy for exactly `MAX_POLLS` polls in one run, which must end in `err`, and for `MAX_POLLS - 1` polls in another, where the last allowed poll must produce `quad_ready`. A reference model reaches its verdict from the polled bytes alone and compares it with both flags on every clock. `qread_req` is held high throughout, so the first cycle of the grant is also judged against the exact cycle in which the model declares the write complete.

// File: rtl/qe_seq.sv
module qe_seq #(
  parameter int GAP       = 4,
  parameter int MAX_POLLS = 2000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] mode,
  output logic       spi_cs_n,
  output logic       byte_req,
  output logic [7:0] byte_out,
  input  logic       byte_ack,
  input  logic [7:0] byte_in,
  output logic       quad_ready,
  output logic       err,
  input  logic       qread_req,
  output logic       qread_grant
);
  localparam int GW = $clog2(GAP + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);

  localparam logic [3:0] IDLE  = 4'd0;
  localparam logic [3:0] PAUSE = 4'd1;
  localparam logic [3:0] RD1   = 4'd2;
  localparam logic [3:0] RD2   = 4'd3;
  localparam logic [3:0] WREN  = 4'd4;
  localparam logic [3:0] WRSR  = 4'd5;
  localparam logic [3:0] POLL  = 4'd6;
  localparam logic [3:0] DONE  = 4'd7;
  localparam logic [3:0] ABORT = 4'd8;

  logic [3:0]    st, nxt;
  logic [1:0]    idx;
  logic [GW-1:0] gcnt;
  logic [PW-1:0] pcnt;
  logic [7:0]    sr1, sr2w;
  logic          check_first;

  wire idle = (st == IDLE) || (st == DONE) || (st == ABORT);
  wire cmd  = (st == RD1) || (st == RD2) || (st == WREN) || (st == WRSR) || (st == POLL);
  wire good = (mode == 3'b100) || (mode == 3'b101);
  wire [1:0] lastidx = (st == WREN) ? 2'd0 : (st == WRSR) ? 2'd2 : 2'd1;
  wire fin = cmd && byte_ack && (idx == lastidx);

  always_comb begin
    byte_out = 8'h00;
    case (st)
      RD1, POLL: byte_out = (idx == 2'd0) ? 8'h05 : 8'h00;
      RD2:       byte_out = (idx == 2'd0) ? 8'h35 : 8'h00;
      WREN:      byte_out = 8'h06;
      WRSR:      byte_out = (idx == 2'd0) ? 8'h01 : (idx == 2'd1) ? sr1 : sr2w;
      default:   byte_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      nxt         <= IDLE;
      idx         <= '0;
      gcnt        <= '0;
      pcnt        <= '0;
      sr1         <= '0;
      sr2w        <= 8'h02;
      check_first <= 1'b0;
    end else begin
      if (cmd && byte_ack) idx <= fin ? 2'd0 : idx + 2'd1;
      case (st)
        IDLE, DONE, ABORT:
          if (start) begin
            st          <= good ? RD1 : ABORT;
            check_first <= mode[0];
            sr2w        <= 8'h02;
          end
        PAUSE:
          if (gcnt == GW'(GAP - 1)) st <= nxt;
          else gcnt <= gcnt + 1'b1;
        RD1:
          if (fin) begin
            sr1  <= byte_in;
            st   <= PAUSE;
            gcnt <= '0;
            nxt  <= check_first ? RD2 : WREN;
          end
        RD2:
          if (fin) begin
            if (byte_in[1]) st <= DONE;
            else begin
              sr2w <= byte_in | 8'h02;
              st   <= PAUSE;
              gcnt <= '0;
              nxt  <= WREN;
            end
          end
        WREN:
          if (fin) begin
            st   <= PAUSE;
            gcnt <= '0;
            nxt  <= WRSR;
          end
        WRSR:
          if (fin) begin
            st   <= PAUSE;
            gcnt <= '0;
            pcnt <= '0;
            nxt  <= POLL;
          end
        POLL:
          if (fin) begin
            if (!byte_in[0]) st <= DONE;
            else if (pcnt == PW'(MAX_POLLS - 1)) st <= ABORT;
            else begin
              pcnt <= pcnt + 1'b1;
              st   <= PAUSE;
              gcnt <= '0;
              nxt  <= POLL;
            end
          end
        default: st <= IDLE;
      endcase
    end
  end

  assign spi_cs_n    = ~cmd;
  assign byte_req    = cmd;
  assign quad_ready  = (st == DONE);
  assign err         = (st == ABORT);
  assign qread_grant = qread_req && quad_ready;
endmodule

// File: rtl/qe_seq_chk.sv
module qe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] mode,
  input logic       idle,
  input logic       spi_cs_n,
  input logic       byte_req,
  input logic [7:0] byte_out,
  input logic       byte_ack,
  input logic       quad_ready,
  input logic       err,
  input logic       qread_grant
);
  assert_req_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> !spi_cs_n);

  assert_tx_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && !byte_ack) |=> (byte_req && $stable(byte_out)));

  assert_gap_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_cs_n) && !quad_ready && !err) |=> spi_cs_n);

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(quad_ready && err));

  assert_grant_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    qread_grant |-> quad_ready);

  assert_bad_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && mode != 3'b100 && mode != 3'b101) |=> (err && spi_cs_n));

  assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_ready && !start) |=> quad_ready);
endmodule

bind qe_seq qe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idle(idle),
  .spi_cs_n(spi_cs_n), .byte_req(byte_req), .byte_out(byte_out),
  .byte_ack(byte_ack), .quad_ready(quad_ready), .err(err),
  .qread_grant(qread_grant)
);

// File: tb/qe_seq_test.sv
`timescale 1ns/100ps
module qe_seq_test;
  localparam int GAPC = 3;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       start = 1'b0, qread_req = 1'b0, byte_ack = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [7:0] byte_in = 8'h00;
  logic       spi_cs_n, byte_req, quad_ready, err, qread_grant;
  logic [7:0] byte_out;

  qe_seq #(.GAP(GAPC), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .spi_cs_n(spi_cs_n), .byte_req(byte_req), .byte_out(byte_out),
    .byte_ack(byte_ack), .byte_in(byte_in), .quad_ready(quad_ready),
    .err(err), .qread_req(qread_req), .qread_grant(qread_grant)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  logic [7:0] exp_q[$];
  bit m_done = 0, m_err = 0, pend_done = 0, pend_err = 0, written = 0;
  bit have_prev = 0, prev_cs_n = 1;
  int busy_left = 0, busy_cfg = 0, polls = 0, idx = 0, gapc = 0, lat = 0;
  logic [7:0] sr1_m = 8'h5C, sr2_m = 8'h00, op = 8'h00;
  string cur_tag = "R3";

  task automatic serve();
    logic [7:0] b, e, resp;
    b = byte_out;
    resp = 8'h00;
    if (exp_q.size() == 0) chk(1'b0, "R6 no traffic expected", b, 0);
    else begin
      e = exp_q.pop_front();
      chk(b == e, cur_tag, b, e);
    end
    if (idx == 0) op = b;
    if (idx == 1 && op == 8'h05) begin
      if (!written) resp = sr1_m;
      else if (busy_left > 0) begin
        resp = sr1_m | 8'h01;
        busy_left--;
        polls++;
        if (polls == MAXP) pend_err = 1;
      end else begin
        resp = sr1_m;
        pend_done = 1;
      end
    end
    if (idx == 1 && op == 8'h35) begin
      resp = sr2_m;
      if (sr2_m[1]) pend_done = 1;
    end
    if (idx == 2 && op == 8'h01) begin
      written = 1;
      polls = 0;
      busy_left = busy_cfg;
    end
    byte_in = resp;
    byte_ack = 1'b1;
    idx++;
  endtask

  // reference model and per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_done) m_done = 1;
      if (pend_err) m_err = 1;
      pend_done = 0;
      pend_err = 0;
      chk(quad_ready == m_done, "R6 ready flag", quad_ready, m_done);
      chk(err == m_err, "R2/R8 error flag", err, m_err);
      chk(qread_grant == (qread_req && m_done), "R9 grant", qread_grant, qread_req && m_done);
      if (byte_req) chk(!spi_cs_n, "R7 request outside frame", spi_cs_n, 0);
      if (prev_cs_n && !spi_cs_n) begin
        if (have_prev) chk(gapc >= GAPC, "R7 gap", gapc, GAPC);
        have_prev = 1;
        idx = 0;
      end
      if (spi_cs_n) gapc++;
      else gapc = 0;
      prev_cs_n = spi_cs_n;
      if (byte_ack) byte_ack = 1'b0;
      else if (byte_req) begin
        if (lat < 1) lat++;
        else begin
          lat = 0;
          serve();
        end
      end
    end
  end

  task automatic push_poll(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(8'h05);
      exp_q.push_back(8'h00);
    end
  endtask

  task automatic run(input logic [2:0] md, input logic [7:0] s2, input int bz, input string tg);
    @(negedge clk);
    #1;
    sr2_m = s2;
    busy_cfg = bz;
    written = 0;
    polls = 0;
    have_prev = 0;
    cur_tag = tg;
    m_done = 0;
    m_err = !(md == 3'b100 || md == 3'b101);
    mode = md;
    start = 1'b1;
    @(negedge clk);
    #1;
    start = 1'b0;
    for (int i = 0; i < 3000 && !(m_done || m_err); i++) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, {tg, " all bytes sent"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    qread_req = 1'b1;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(spi_cs_n == 1, "R1 cs", spi_cs_n, 1);
    chk(byte_req == 0, "R1 req", byte_req, 0);
    chk(quad_ready == 0, "R1 ready", quad_ready, 0);
    chk(err == 0, "R1 err", err, 0);
    chk(qread_grant == 0, "R1 grant", qread_grant, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1 && quad_ready == 0, "R1 after release", {spi_cs_n, quad_ready}, 2);

    // R2 unsupported codes
    run(3'b110, 8'h00, 0, "R2");
    chk(err == 1 && spi_cs_n == 1, "R2 code 110", {err, spi_cs_n}, 3);
    run(3'b000, 8'h00, 0, "R2");
    chk(err == 1 && byte_req == 0, "R2 code 000", {err, byte_req}, 2);

    // R3 blind write, R10 restart from error
    exp_q = '{8'h05, 8'h00, 8'h06, 8'h01, 8'h5C, 8'h02};
    push_poll(4);
    run(3'b100, 8'h00, 3, "R3");
    chk(quad_ready == 1 && err == 0, "R10 restart from error", {quad_ready, err}, 2);
    chk(qread_grant == 1, "R9 grant after ready", qread_grant, 1);
    qread_req = 1'b0;
    @(negedge clk);
    chk(qread_grant == 0, "R9 grant without request", qread_grant, 0);
    qread_req = 1'b1;

    // R4 already set: no write
    exp_q = '{8'h05, 8'h00, 8'h35, 8'h00};
    run(3'b101, 8'h02, 0, "R4");
    chk(quad_ready == 1, "R4 ready without write", quad_ready, 1);

    // R5 read-modify-write
    exp_q = '{8'h05, 8'h00, 8'h35, 8'h00, 8'h06, 8'h01, 8'h5C, 8'h42};
    push_poll(3);
    run(3'b101, 8'h40, 2, "R5");
    chk(quad_ready == 1, "R5 ready", quad_ready, 1);

    // R8 timeout: busy on every allowed poll
    exp_q = '{8'h05, 8'h00, 8'h06, 8'h01, 8'h5C, 8'h02};
    push_poll(MAXP);
    run(3'b100, 8'h00, MAXP, "R8");
    chk(err == 1 && quad_ready == 0, "R8 timeout", {err, quad_ready}, 2);
    chk(qread_grant == 0, "R9 no grant on error", qread_grant, 0);

    // R8/R6 boundary: last allowed poll reports idle
    exp_q = '{8'h05, 8'h00, 8'h35, 8'h00, 8'h06, 8'h01, 8'h5C, 8'h02};
    push_poll(MAXP);
    run(3'b101, 8'h00, MAXP - 1, "R8");
    chk(quad_ready == 1 && err == 0, "R8 idle on last poll", {quad_ready, err}, 2);

    // R6 immediate idle after write
    exp_q = '{8'h05, 8'h00, 8'h06, 8'h01, 8'h5C, 8'h02};
    push_poll(1);
    run(3'b100, 8'h00, 0, "R6");
    chk(quad_ready == 1, "R6 single poll", quad_ready, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule